// File: doc/BRIEF.md
# Block Floating Point Output Normaliser

This block takes 16-bit words leaving a block-floating-point transform engine and rescales each one to a single common exponent chosen by the user, so that results from different transforms can be compared or stored in one fixed-point format. Each incoming word carries two exponent parts. One is a 5-bit global exponent that belongs to the whole transform. The other is a 2-bit tag that belongs to the word alone. The block adds the two, subtracts the total from the universal exponent, and arithmetically shifts the word right by the difference.

The shift is worked out with 4-bit arithmetic only. When the word exponent does not fit in four bits, or when the subtraction borrows, the shift is forced to its maximum of 15 places. Real and imaginary parts of a complex value may pass through the block on alternate cycles. An imaginary word reuses the shift that was computed for the most recent real word. The caller supplies the universal exponent already raised by one, which compensates for adding the tag directly to the global exponent. The path has one register stage, and a valid flag travels with the data.

Top module: `bfp_out_norm`

## Requirements
- R1: The word exponent is the plain sum of the 5-bit global exponent `in_gexp` and the 2-bit tag `in_tag`, with no table adjustment.
- R2: For a real word whose exponent sum is at most 15 and at most `in_uexp`, the right shift is `in_uexp` minus that sum (a value from 0 to 15).
- R3: For a real word whose exponent sum is 16 or more, the shift is forced to 15.
- R4: For a real word whose exponent sum is greater than `in_uexp` (the 4-bit subtraction borrows), the shift is forced to 15.
- R5: The shift is arithmetic: bit 15 of the data is copied into every vacated high bit, and the output sign equals the input sign.
- R6: A word accepted with `in_valid` high appears on `out_data` one clock later with `out_valid` high, and `out_imag` repeats that word's `in_imag`; `out_valid` is otherwise low.
- R7: A word with `in_imag` = 1 is shifted by the amount held from the most recent valid real word (`in_imag` = 0); its own `in_tag`, `in_gexp` and `in_uexp` have no effect.
- R8: While `rst_n` is low, `out_valid`, `out_imag` and `out_data` are zero and the held shift is zero, so an imaginary word arriving before any real word is passed unshifted.
- R9: A cycle with `in_valid` low leaves `out_data` and the held shift unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_imag | input | 1 | 1 = imaginary part (reuse held shift), 0 = real part |
| in_data | input | 16 | Two's complement data word |
| in_tag | input | 2 | Per-word exponent tag |
| in_gexp | input | 5 | Global exponent of the transform |
| in_uexp | input | 4 | Universal exponent, already raised by one |
| out_valid | output | 1 | Normalised word present |
| out_imag | output | 1 | Real/imaginary flag of the output word |
| out_data | output | 16 | Normalised data word |

## Verification
The assertions watch, on every cycle, the one-cycle latency of the valid flag, the sign of every output matching its input, a trapped real word collapsing to pure sign bits, an unshifted word passing through untouched, and the held shift and output staying still on idle or imaginary cycles. Only the bench scenarios show the exact shift amounts across the whole space of global exponent, tag and universal exponent, the boundary between a 15-place computed shift and a trap, and the pairing of an imaginary word with the real word before it across idle cycles and reset.

// File: rtl/bfp_norm_pkg.sv
package bfp_norm_pkg;

  localparam int DATA_W  = 16;
  localparam int GEXP_W  = 5;
  localparam int TAG_W   = 2;
  localparam int SHIFT_W = 4;

  // Word exponent: global exponent plus tag, one extra bit for the carry.
  function automatic logic [GEXP_W:0] word_exp_sum(
    input logic [GEXP_W-1:0] gexp,
    input logic [TAG_W-1:0]  tag
  );
    return {1'b0, gexp} + {{(GEXP_W + 1 - TAG_W){1'b0}}, tag};
  endfunction

  // Narrow subtraction with the borrow returned in the top bit.
  function automatic logic [SHIFT_W:0] narrow_diff(
    input logic [SHIFT_W-1:0] uexp,
    input logic [SHIFT_W-1:0] wexp
  );
    return {1'b0, uexp} - {1'b0, wexp};
  endfunction

endpackage

// File: rtl/bfp_shift_calc.sv
module bfp_shift_calc
  import bfp_norm_pkg::*;
#(
  parameter int GW = GEXP_W,
  parameter int TW = TAG_W,
  parameter int SW = SHIFT_W
) (
  input  logic [GW-1:0] gexp,
  input  logic [TW-1:0] tag,
  input  logic [SW-1:0] uexp,
  output logic [SW-1:0] shamt,
  output logic          trap_wide,
  output logic          trap_borrow
);

  localparam logic [SW-1:0] MAX_SHIFT = '1;

  logic [GW:0] sum_full;
  logic [SW:0] diff_full;

  always_comb begin
    sum_full    = {1'b0, gexp} + {{(GW + 1 - TW){1'b0}}, tag};
    trap_wide   = |sum_full[GW:SW];
    diff_full   = {1'b0, uexp} - {1'b0, sum_full[SW-1:0]};
    trap_borrow = diff_full[SW];
    if (trap_wide || trap_borrow) shamt = MAX_SHIFT;
    else                          shamt = diff_full[SW-1:0];
  end

endmodule

// File: rtl/bfp_shift_hold.sv
module bfp_shift_hold #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] shamt_in,
  output logic [SW-1:0] shamt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shamt_q <= '0;
    else if (load) shamt_q <= shamt_in;
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shamt_q));

endmodule

// File: rtl/bfp_arith_shifter.sv
module bfp_arith_shifter #(
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] shamt,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic sgn;
    assign sgn = stage[i][DW-1];
    if (STEP >= DW) begin : g_full
      assign stage[i+1] = shamt[i] ? {DW{sgn}} : stage[i];
    end else begin : g_part
      assign stage[i+1] = shamt[i] ? {{STEP{sgn}}, stage[i][DW-1:STEP]}
                                   : stage[i];
    end
  end

  assign dout = stage[SW];

endmodule

// File: rtl/bfp_out_norm.sv
module bfp_out_norm
  import bfp_norm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int GW = GEXP_W,
  parameter int TW = TAG_W,
  parameter int SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_imag,
  input  logic [DW-1:0] in_data,
  input  logic [TW-1:0] in_tag,
  input  logic [GW-1:0] in_gexp,
  input  logic [SW-1:0] in_uexp,
  output logic          out_valid,
  output logic          out_imag,
  output logic [DW-1:0] out_data
);

  // Internal events, named for the assertions.
  logic [SW-1:0] calc_shamt;
  logic [SW-1:0] held_shamt;
  logic [SW-1:0] use_shamt;
  logic          trap_wide;
  logic          trap_borrow;
  logic          real_load;
  logic [DW-1:0] shifted;

  bfp_shift_calc #(.GW(GW), .TW(TW), .SW(SW)) u_calc (
    .gexp        (in_gexp),
    .tag         (in_tag),
    .uexp        (in_uexp),
    .shamt       (calc_shamt),
    .trap_wide   (trap_wide),
    .trap_borrow (trap_borrow)
  );

  assign real_load = in_valid && !in_imag;

  bfp_shift_hold #(.SW(SW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (real_load),
    .shamt_in (calc_shamt),
    .shamt_q  (held_shamt)
  );

  assign use_shamt = in_imag ? held_shamt : calc_shamt;

  bfp_arith_shifter #(.DW(DW), .SW(SW)) u_shift (
    .din   (in_data),
    .shamt (use_shamt),
    .dout  (shifted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_imag  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_imag <= in_imag;
        out_data <= shifted;
      end
    end
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R5
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> out_data[DW-1] == $past(in_data[DW-1]));

  // R3 R4
  trap_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(real_load && (trap_wide || trap_borrow))
      |-> out_data == {DW{$past(in_data[DW-1])}});

  // R2
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && use_shamt == '0) |-> out_data == $past(in_data));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(out_data));

endmodule

// File: tb/sim_bfp_out_norm.sv
module sim_bfp_out_norm;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_imag;
  logic [15:0] in_data;
  logic [1:0]  in_tag;
  logic [4:0]  in_gexp;
  logic [3:0]  in_uexp;
  logic        out_valid, out_imag;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  bfp_out_norm u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_imag(in_imag),
    .in_data(in_data), .in_tag(in_tag), .in_gexp(in_gexp), .in_uexp(in_uexp),
    .out_valid(out_valid), .out_imag(out_imag), .out_data(out_data)
  );

  // {imag, tag, gexp, uexp, data, expected}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 2'd0, 5'd0,  4'd0,  16'h4000, 16'h4000},  // R2 zero shift
    {1'b0, 2'd1, 5'd2,  4'd7,  16'h4000, 16'h0400},  // R1 R2 shift 4
    {1'b0, 2'd3, 5'd5,  4'd8,  16'h8000, 16'h8000},  // R1 sum 8, shift 0
    {1'b0, 2'd2, 5'd1,  4'd15, 16'h8000, 16'hFFF8},  // R5 shift 12 negative
    {1'b1, 2'd0, 5'd0,  4'd0,  16'h1000, 16'h0001},  // R7 reuse 12
    {1'b0, 2'd0, 5'd16, 4'd15, 16'h7FFF, 16'h0000},  // R3 sum 16
    {1'b1, 2'd0, 5'd0,  4'd15, 16'h8001, 16'hFFFF},  // R7 reuse 15
    {1'b0, 2'd3, 5'd14, 4'd15, 16'h1234, 16'h0000},  // R3 sum 17
    {1'b0, 2'd2, 5'd6,  4'd5,  16'hC000, 16'hFFFF},  // R4 borrow
    {1'b0, 2'd0, 5'd15, 4'd15, 16'h8000, 16'h8000},  // R2 sum 15 boundary
    {1'b0, 2'd1, 5'd0,  4'd0,  16'h7FFF, 16'h0000},  // R4 borrow by one
    {1'b0, 2'd0, 5'd0,  4'd15, 16'h8000, 16'hFFFF},  // R2 computed 15
    {1'b0, 2'd1, 5'd2,  4'd9,  16'hABCD, 16'hFEAF},  // R5 shift 6
    {1'b1, 2'd3, 5'd31, 4'd0,  16'h5555, 16'h0155}   // R7 reuse 6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic im, input logic [1:0] t,
                       input logic [4:0] g, input logic [3:0] u, input logic [15:0] d);
    in_valid = v; in_imag = im; in_tag = t; in_gexp = g; in_uexp = u; in_data = d;
  endtask

  // Independent model: floor division by a power of two.
  function automatic logic [15:0] model(input int t, input int g, input int u,
                                        input logic [15:0] d);
    int we, sh, val, dv, res;
    we = g + t;
    sh = (we > 15 || we > u) ? 15 : u - we;
    val = int'($signed(d));
    dv = 1 << sh;
    if (val >= 0) res = val / dv;
    else          res = -((-val + dv - 1) / dv);
    return res[15:0];
  endfunction

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 2'd0, 5'd0, 4'd0, 16'h0);
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R8 out_data in reset", out_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][43], VEC[i][42:41], VEC[i][40:36], VEC[i][35:32], VEC[i][31:16]);
      @(negedge clk);
      check($sformatf("R1-table vec %0d data", i), out_data, VEC[i][15:0]);
      check("R6 out_valid/out_imag", {14'd0, out_valid, out_imag}, {14'd0, 1'b1, VEC[i][43]});
    end

    // R9: idle cycle with inputs that would give shift 15 if loaded
    drive(1'b0, 1'b0, 2'd0, 5'd0, 4'd15, 16'h1111);
    @(negedge clk);
    check("R6 out_valid low when idle", {15'd0, out_valid}, 16'd0);
    check("R9 out_data held when idle", out_data, 16'h0155);
    // R7 R9: imaginary word still uses shift 6 from last real word
    drive(1'b1, 1'b1, 2'd0, 5'd0, 4'd15, 16'h4000);
    @(negedge clk);
    check("R7 R9 held shift after idle", out_data, 16'h0100);

    // R8: reset clears held shift
    drive(1'b0, 1'b0, 2'd0, 5'd0, 4'd0, 16'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 out_data after reset", out_data, 16'h0000);
    check("R8 out_imag after reset", {15'd0, out_imag}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 1'b1, 2'd3, 5'd9, 4'd2, 16'h7000);
    @(negedge clk);
    check("R8 imag before any real unshifted", out_data, 16'h7000);

    // Sweep of the whole exponent space against the model
    for (int t = 0; t < 4; t++) begin
      for (int g = 0; g < 32; g++) begin
        for (int u = 0; u < 16; u++) begin
          logic [15:0] d;
          int we;
          string req;
          d = 16'h8000 ^ 16'(g * 577 + t * 97 + u * 13);
          we = g + t;
          req = (we > 15) ? "R3" : ((we > u) ? "R4" : "R2");
          drive(1'b1, 1'b0, 2'(t), 5'(g), 4'(u), d);
          @(negedge clk);
          check($sformatf("%s R1 sweep t=%0d g=%0d u=%0d", req, t, g, u),
                out_data, model(t, g, u, d));
        end
      end
    end

    drive(1'b0, 1'b0, 2'd0, 5'd0, 4'd0, 16'h0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule